// File: doc/BRIEF.md
# PHY Event Interrupt Register Unit

This unit sits between the event outputs of a network PHY core and the host's management access path. Each event the core reports arrives as a one-cycle pulse on a 16-bit vector: link state, speed and duplex changes, MDI-X and polarity changes, auto-downspeed, auto-negotiation done or failed, next-page traffic, master/slave resolution failure and wake-up. The unit latches every pulse into a sticky pending bit. It keeps an enable mask alongside the pending bits and raises one active-high interrupt line whenever an enabled bit is pending.

Software reaches the two registers through a small register port. One address holds the enable mask and can be read and written. The other holds the pending bits. Reading that address returns every pending bit and clears them all in the same access, and writes to it are dropped. A typical driver clears the mask during initialisation, drains stale events with a status read, and then enables only the link state and downspeed events (0x0021).

Top module: `phy_evt_irq_unit`

## Requirements
- R1: After reset the pending bits, the mask, the read data and `irq_o` are all 0.
- R2: A pulse on an implemented bit of `evt_i` sets that pending bit at the next clock edge. The bit stays set until a status read. Bit positions: 0 link state, 1 link speed, 2 duplex, 3 MDI-X, 4 MDI polarity, 5 auto-downspeed, 10 auto-negotiation done, 11 auto-negotiation error, 12 next page sent, 13 next page received, 14 master/slave error, 15 wake-up.
- R3: Bits 6 to 9 are reserved. They are never set in either register and always read as 0, so a pulse on all 16 inputs reads back as 0xFC3F.
- R4: A write to the mask address (0x04) stores `reg_wdata` with the reserved bits forced to 0. A read of the mask address returns the stored value and changes nothing.
- R5: A read of the status address (0x05) presents the pending bits on `reg_rdata` in the cycle after the read strobe and clears all of them.
- R6: An event pulse in the same cycle as a status read is not part of that read's data. It stays pending afterwards.
- R7: `irq_o` is 1 in the cycle after (pending AND mask) is non-zero and 0 in the cycle after it is zero. Pending bits that are not enabled never raise it.
- R8: Enabling a mask bit while its event is already pending raises `irq_o` one cycle after the write. Writing 0 to the mask drops `irq_o` and leaves the pending bits in place.
- R9: Writes to the status address are ignored. Reads of any address other than 0x04 and 0x05 return 0, and writes to such addresses leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| evt_i | input | 16 | One-cycle event pulses from the PHY core |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| irq_o | output | 1 | Level interrupt toward the host |

## Verification
The risky overlap is a new event pulse landing in the same cycle as a clear-on-read of the status register. The bench provokes it by asserting `reg_rd` at the status address together with an `evt_i` pulse, after first leaving a different event pending. The read must return only the older event, and a second read must return the new one. Mask writes that land on an already pending event are a second overlap. Those are judged by the cycle on which `irq_o` rises.

// File: rtl/phy_evt_pkg.sv
package phy_evt_pkg;
   localparam int unsigned EVT_W_DEF = 16;

   // bit positions of the event vector
   localparam int unsigned B_LINK      = 0;
   localparam int unsigned B_SPEED     = 1;
   localparam int unsigned B_DUPLEX    = 2;
   localparam int unsigned B_MDIX      = 3;
   localparam int unsigned B_POLARITY  = 4;
   localparam int unsigned B_DOWNSPEED = 5;
   localparam int unsigned B_AN_DONE   = 10;
   localparam int unsigned B_AN_ERR    = 11;
   localparam int unsigned B_NP_TX     = 12;
   localparam int unsigned B_NP_RX     = 13;
   localparam int unsigned B_MS_ERR    = 14;
   localparam int unsigned B_WAKE      = 15;

   // implemented bits: 0..5 and 10..15, reserved 6..9
   localparam logic [EVT_W_DEF-1:0] IMPL_DEF = 16'hFC3F;
   // common enable set: link state plus downspeed
   localparam logic [EVT_W_DEF-1:0] TYPICAL_ENABLE = 16'h0021;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_MASK   = 2'd1,
      SEL_STATUS = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/phy_evt_status_bank.sv
module phy_evt_status_bank #(
   parameter int unsigned      EVT_W     = 16,
   parameter logic [EVT_W-1:0] IMPL_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_i,
   input  logic             clr_i,
   output logic [EVT_W-1:0] status_o
);
   for (genvar b = 0; b < EVT_W; b++) begin : g_bit
      if (IMPL_MASK[b]) begin : g_impl
         logic pend_q;
         // a new pulse wins over the clear so nothing is lost
         always_ff @(posedge clk) begin
            if (!rst_n)        pend_q <= 1'b0;
            else if (evt_i[b]) pend_q <= 1'b1;
            else if (clr_i)    pend_q <= 1'b0;
         end
         assign status_o[b] = pend_q;
      end else begin : g_rsvd
         logic unused_evt;
         assign unused_evt  = evt_i[b];
         assign status_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/phy_evt_mask_reg.sv
module phy_evt_mask_reg #(
   parameter int unsigned      EVT_W     = 16,
   parameter logic [EVT_W-1:0] IMPL_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [EVT_W-1:0] wdata,
   output logic [EVT_W-1:0] mask_o
);
   logic [EVT_W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     mask_q <= '0;
      else if (wr_en) mask_q <= wdata & IMPL_MASK;
   end

   assign mask_o = mask_q;
endmodule

// File: rtl/phy_evt_irq_gen.sv
module phy_evt_irq_gen #(
   parameter int unsigned EVT_W      = 16,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] status_i,
   input  logic [EVT_W-1:0] mask_i,
   output logic             irq_o
);
   logic any_enabled;
   assign any_enabled = |(status_i & mask_i);

   if (REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_enabled;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_o      = any_enabled;
   end
endmodule

// File: rtl/phy_evt_irq_unit.sv
module phy_evt_irq_unit #(
   parameter int unsigned      EVT_W          = phy_evt_pkg::EVT_W_DEF,
   parameter logic [EVT_W-1:0] IMPL_MASK      = phy_evt_pkg::IMPL_DEF,
   parameter int unsigned      ADDR_W         = 5,
   parameter int unsigned      MASK_ADDR      = 4,
   parameter int unsigned      STAT_ADDR      = 5,
   parameter bit               IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_W-1:0]  evt_i,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [EVT_W-1:0]  reg_wdata,
   output logic [EVT_W-1:0]  reg_rdata,
   output logic              irq_o
);
   import phy_evt_pkg::*;

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   // elaboration-time parameter checks
   if (EVT_W < 1 || EVT_W > 32) begin : g_bad_width
      $error("phy_evt_irq_unit: EVT_W out of range");
   end
   if (MASK_ADDR == STAT_ADDR) begin : g_bad_alias
      $error("phy_evt_irq_unit: mask and status share an address");
   end
   if (MASK_ADDR >= ADDR_SPAN || STAT_ADDR >= ADDR_SPAN) begin : g_bad_addr
      $error("phy_evt_irq_unit: register address exceeds ADDR_W");
   end

   reg_sel_e         sel;
   logic             clr_status;
   logic             wr_mask;
   logic [EVT_W-1:0] status_q;
   logic [EVT_W-1:0] mask_q;
   logic [EVT_W-1:0] rdata_q;

   always_comb begin
      if (reg_addr == ADDR_W'(MASK_ADDR))      sel = SEL_MASK;
      else if (reg_addr == ADDR_W'(STAT_ADDR)) sel = SEL_STATUS;
      else                                     sel = SEL_NONE;
   end

   assign clr_status = reg_rd && (sel == SEL_STATUS);
   assign wr_mask    = reg_wr && (sel == SEL_MASK);

   phy_evt_status_bank #(.EVT_W(EVT_W), .IMPL_MASK(IMPL_MASK)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i),
      .clr_i    (clr_status),
      .status_o (status_q)
   );

   phy_evt_mask_reg #(.EVT_W(EVT_W), .IMPL_MASK(IMPL_MASK)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_mask),
      .wdata  (reg_wdata),
      .mask_o (mask_q)
   );

   phy_evt_irq_gen #(.EVT_W(EVT_W), .REGISTERED(IRQ_REGISTERED)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_q),
      .mask_i   (mask_q),
      .irq_o    (irq_o)
   );

   // read data captures the pre-clear status value
   always_ff @(posedge clk) begin
      if (!rst_n) rdata_q <= '0;
      else if (reg_rd) begin
         unique case (sel)
            SEL_MASK:   rdata_q <= mask_q;
            SEL_STATUS: rdata_q <= status_q;
            default:    rdata_q <= '0;
         endcase
      end
   end

   assign reg_rdata = rdata_q;
endmodule

// File: rtl/phy_evt_irq_chk.sv
module phy_evt_irq_chk #(
   parameter int unsigned      EVT_W          = 16,
   parameter logic [EVT_W-1:0] IMPL_MASK      = '1,
   parameter int unsigned      ADDR_W         = 5,
   parameter int unsigned      MASK_ADDR      = 4,
   parameter int unsigned      STAT_ADDR      = 5,
   parameter bit               IRQ_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [EVT_W-1:0]  evt_i,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [EVT_W-1:0]  reg_wdata,
   input logic [EVT_W-1:0]  reg_rdata,
   input logic [EVT_W-1:0]  status_q,
   input logic [EVT_W-1:0]  mask_q,
   input logic              irq_o
);
   logic             rd_stat;
   logic             wr_mask;
   logic             wr_stat;
   logic [EVT_W-1:0] evt_impl;

   assign rd_stat  = reg_rd && (reg_addr == ADDR_W'(STAT_ADDR));
   assign wr_mask  = reg_wr && (reg_addr == ADDR_W'(MASK_ADDR));
   assign wr_stat  = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));
   assign evt_impl = evt_i & IMPL_MASK;

   // R2 / R6: every implemented pulse is pending after the edge, read or not
   a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_impl != '0) |=> ((status_q & $past(evt_impl)) == $past(evt_impl)));

   // R2: pending bits persist while no status read happens
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

   // R3: reserved positions never show up in read data
   a_r3_rsvd_rdata: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~IMPL_MASK) == '0);

   // R4: mask write lands with reserved bits cleared
   a_r4_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |=> (mask_q == $past(reg_wdata & IMPL_MASK)));

   // R5: status read returns the old value and leaves only same-cycle events
   a_r5_read_data: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat |=> (reg_rdata == $past(status_q)));
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && evt_impl == '0) |=> (status_q == '0));

   // R9: a status write with no read or event changes nothing
   a_r9_stat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !reg_rd && evt_impl == '0) |=> $stable(status_q));

   if (IRQ_REGISTERED) begin : g_irq_chk
      // R7: interrupt follows enabled pending bits one cycle later
      a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
         ((status_q & mask_q) != '0) |=> irq_o);
      a_r7_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
         ((status_q & mask_q) == '0) |=> !irq_o);
   end
endmodule

bind phy_evt_irq_unit phy_evt_irq_chk #(
   .EVT_W(EVT_W), .IMPL_MASK(IMPL_MASK), .ADDR_W(ADDR_W),
   .MASK_ADDR(MASK_ADDR), .STAT_ADDR(STAT_ADDR), .IRQ_REGISTERED(IRQ_REGISTERED)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
   .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .status_q(status_q), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/test_phy_evt_irq_unit.sv
module test_phy_evt_irq_unit;
   localparam logic [4:0] A_MASK = 5'h04;
   localparam logic [4:0] A_STAT = 5'h05;
   localparam logic [4:0] A_NONE = 5'h1F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] evt_i = '0;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   typedef struct {
      logic [15:0] exp;
      string       tag;
   } sb_item_t;
   sb_item_t sb_q[$];
   logic rd_d = 1'b0;

   phy_evt_irq_unit i_phy_evt_irq_unit (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   always #10 clk = ~clk;

   // monitor: a read strobe seen at an edge is judged at the next negedge
   always @(posedge clk) rd_d <= reg_rd;
   always @(negedge clk) begin
      if (rd_d) begin
         n_checks++;
         if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard: unexpected read data, actual %h expected none", reg_rdata);
         end else begin
            sb_item_t it;
            it = sb_q.pop_front();
            if (reg_rdata !== it.exp) begin
               n_fail++;
               $display("FAIL %s: rdata actual %h expected %h", it.tag, reg_rdata, it.exp);
            end
         end
      end
   end

   task automatic chk_irq(input string tag, input logic exp);
      n_checks++;
      if (irq_o !== exp) begin
         n_fail++;
         $display("FAIL %s: irq_o actual %b expected %b", tag, irq_o, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse(input logic [15:0] v);
      evt_i = v;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic do_read(input logic [4:0] a, input logic [15:0] exp, input string tag);
      sb_item_t it;
      it.exp = exp;
      it.tag = tag;
      sb_q.push_back(it);
      reg_addr = a;
      reg_rd   = 1'b1;
      @(negedge clk);
      reg_rd   = 1'b0;
   endtask

   task automatic read_with_event(input logic [15:0] exp, input logic [15:0] v, input string tag);
      sb_item_t it;
      it.exp = exp;
      it.tag = tag;
      sb_q.push_back(it);
      reg_addr = A_STAT;
      reg_rd   = 1'b1;
      evt_i    = v;
      @(negedge clk);
      reg_rd   = 1'b0;
      evt_i    = '0;
   endtask

   task automatic do_write(input logic [4:0] a, input logic [15:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: reset state
      chk_irq("R1 irq after reset", 1'b0);
      do_read(A_MASK, 16'h0000, "R1 mask after reset");
      do_read(A_STAT, 16'h0000, "R1 status after reset");

      // R2 / R5: single event, sticky, then clear on read
      pulse(16'h0001);
      idle(2);
      chk_irq("R7 masked-out pending bit", 1'b0);
      do_read(A_STAT, 16'h0001, "R2 link event pending");
      do_read(A_STAT, 16'h0000, "R5 status cleared by read");

      // R3: all inputs pulsed, reserved bits stay clear
      pulse(16'hFFFF);
      do_read(A_STAT, 16'hFC3F, "R3 all events reserved clear");
      do_write(A_MASK, 16'hFFFF);
      do_read(A_MASK, 16'hFC3F, "R3 mask reserved clear");

      // R4: typical enable set
      do_write(A_MASK, 16'h0021);
      do_read(A_MASK, 16'h0021, "R4 mask readback");
      do_read(A_MASK, 16'h0021, "R4 mask read has no side effect");

      // R7: non-enabled event keeps irq low, enabled event raises it
      pulse(16'h0002);
      idle(1);
      chk_irq("R7 speed event not enabled", 1'b0);
      pulse(16'h0001);
      idle(1);
      chk_irq("R7 link event enabled", 1'b1);
      do_read(A_STAT, 16'h0003, "R5 read returns both events");
      chk_irq("R7 irq one cycle after clear", 1'b1);
      idle(1);
      chk_irq("R7 irq low after clear", 1'b0);

      // R8: enable while pending, then disable
      do_write(A_MASK, 16'h0000);
      pulse(16'h8000);
      idle(1);
      chk_irq("R8 wake pending but masked", 1'b0);
      do_write(A_MASK, 16'h8000);
      idle(1);
      chk_irq("R8 enable raises irq for pending event", 1'b1);
      do_write(A_MASK, 16'h0000);
      idle(1);
      chk_irq("R8 zero mask drops irq", 1'b0);
      do_read(A_STAT, 16'h8000, "R8 pending kept while masked");

      // R6: event in the same cycle as a status read
      pulse(16'h0400);
      read_with_event(16'h0400, 16'h0004, "R6 read excludes same-cycle event");
      do_read(A_STAT, 16'h0004, "R6 same-cycle event still pending");
      do_read(A_STAT, 16'h0000, "R6 second read clears it");

      // R9: status write ignored, unmapped access
      pulse(16'h0020);
      do_write(A_STAT, 16'h0000);
      do_read(A_STAT, 16'h0020, "R9 status write ignored");
      do_write(A_MASK, 16'h0021);
      do_write(A_NONE, 16'hFFFF);
      do_read(A_MASK, 16'h0021, "R9 unmapped write leaves mask");
      do_read(A_NONE, 16'h0000, "R9 unmapped read is zero");

      idle(3);
      n_checks++;
      if (sb_q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: leftover items actual %0d expected 0", sb_q.size());
      end
      finish_run();
   end
endmodule